// File: doc/BRIEF.md
# Serial Audio Interrupt Status Register

This block keeps the interrupt status word of a two-channel synchronous serial audio port. The serial datapath feeds it level flags, event pulses and received control-link fields. The block turns these into one read-only 32-bit status word and a single masked interrupt request. Level flags are data ready, transmit data empty, receive FIFO full, transmit FIFO empty, frame sync and last-slot sync. Event pulses are receive overrun and transmit underrun. The received control-link fields are command address, command data and tag.

The level flags are only refreshed on the cycle that the datapath marks as the end of the first bit of the next serial word. Overrun and underrun flags are sticky. Software clears one by reading the status word and then touching the matching channel's data register. Each of the three control-link fields has a flag that sets when a newly received value differs from the previous one. That flag clears when software reads the matching holding register. The interrupt request combines every status bit with its enable bit and with the transmit or receive enable of the side that the bit belongs to.

Top module: `sai_irq_status`

## Requirements
- R1: After reset the status word is 32'h0000_0003: the transmit-data-empty flags of both channels read 1 and every other bit reads 0.
- R2: The level flags load from their inputs only on a clock edge where `firstBitDone` is high, and they hold their value otherwise. The level flags are transmit data empty ch0/ch1 at bits 0/1, receive data ready ch0/ch1 at bits 2/3, transmit FIFO empty ch0/ch1 at bits 8/9, receive FIFO full ch0/ch1 at bits 10/11, transmit frame sync at bit 12, receive frame sync at bit 13, transmit last slot at bit 14 and receive last slot at bit 15.
- R3: A pulse on `rxOverrunEv[n]` sets the overrun flag at bit 6+n. A pulse on `txUnderrunEv[n]` sets the underrun flag at bit 4+n. Both appear in the status word one cycle later.
- R4: An overrun or underrun flag clears only when both steps happen in order. First comes a status read (`statusRd`) while the flag is set. Then, in a later cycle, comes a receive-data read (`rxDataRd[n]`, for overrun) or a transmit-data write (`txDataWr[n]`, for underrun) of the same channel. A data access with no earlier status read, a status read and data access in the same cycle, or an access to the other channel does not clear the flag.
- R5: A new overrun or underrun event that arrives after the status read and before the data access cancels the pending clear. The flag then stays set through the following data access.
- R6: The command-address-changed flag (bit 18) sets when `ac97Valid` delivers a command address that differs from the last one received. It clears when `cmdAddrRd` is pulsed. The previous value resets to zero.
- R7: The command-data-changed flag (bit 17) sets when `ac97Valid` delivers command data that differs from the last data received. It clears when `cmdDataRd` is pulsed.
- R8: The tag-changed flag (bit 16) sets when `ac97Valid` delivers a tag that differs from the last tag received. It clears when `tagRd` is pulsed.
- R9: When a set event and a clearing access land on a flag in the same cycle, the flag ends up set.
- R10: Bits 31 to 19 of the status word always read 0.
- R11: `irq` is the OR over bits 0 to 18 of (status bit AND `irqEnable` bit AND side enable). Bits 2, 3, 6, 7, 10, 11, 13, 15, 16, 17 and 18 are receive-side bits and need `rxEnable`. Bits 0, 1, 4, 5, 8, 9, 12 and 14 are transmit-side bits and need `txEnable`.
- R12: `irq` responds in the same cycle to changes of `irqEnable`, `rxEnable` and `txEnable`, with no register in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| firstBitDone | input | 1 | Marks the cycle in which the first bit of the next word has been shifted |
| rxDataReady | input | 2 | Per-channel receive data ready level |
| txDataEmpty | input | 2 | Per-channel transmit data empty level |
| rxFifoFull | input | 2 | Per-channel receive FIFO full level |
| txFifoEmpty | input | 2 | Per-channel transmit FIFO empty level |
| txFrameSync | input | 1 | Transmit frame sync level |
| rxFrameSync | input | 1 | Receive frame sync level |
| txLastSlot | input | 1 | Transmit last time slot level |
| rxLastSlot | input | 1 | Receive last time slot level |
| rxOverrunEv | input | 2 | Per-channel receive overrun pulse |
| txUnderrunEv | input | 2 | Per-channel transmit underrun pulse |
| ac97Valid | input | 1 | New command address, command data and tag are present |
| ac97CmdAddr | input | ADDR_W | Received command address |
| ac97CmdData | input | DATA_W | Received command data |
| ac97Tag | input | TAG_W | Received tag |
| txEnable | input | 1 | Transmitter enable |
| rxEnable | input | 1 | Receiver enable |
| irqEnable | input | 19 | Per-bit interrupt enable |
| statusRd | input | 1 | Bus read of the status word |
| rxDataRd | input | 2 | Bus read of a channel's receive data register |
| txDataWr | input | 2 | Bus write of a channel's transmit data register |
| cmdAddrRd | input | 1 | Bus read of the command address holding register |
| cmdDataRd | input | 1 | Bus read of the command data holding register |
| tagRd | input | 1 | Bus read of the tag holding register |
| statusWord | output | 32 | Status word |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench targets the order of the two-step clear. It runs a data access with no earlier status read, a status read and data access in the same cycle, an access to the wrong channel, and a fresh overrun between the two steps. A design that armed too eagerly or forgot to drop the arming would clear the flag early and lose an overrun. For the change-detect flags, the bench repeats identical values and sends a change in the same cycle as the clearing read. A design that flagged every receive, or let the clear win, would report false updates or drop real ones. A level vector presented without the first-bit marker must leave the word unchanged, and a receive-side interrupt must stay quiet while only the transmitter is enabled.

// File: rtl/sai_irq_pkg.sv
package sai_irq_pkg;

  localparam int NUM_CH   = 2;
  localparam int STATUS_W = 32;
  localparam int FLAG_W   = 19;

  // Bit positions inside the status word (per-channel fields add the channel index)
  localparam int BIT_TX_EMPTY      = 0;
  localparam int BIT_RX_READY      = 2;
  localparam int BIT_TX_UNDER      = 4;
  localparam int BIT_RX_OVER       = 6;
  localparam int BIT_TX_FIFO_EMPTY = 8;
  localparam int BIT_RX_FIFO_FULL  = 10;
  localparam int BIT_TX_FSYNC      = 12;
  localparam int BIT_RX_FSYNC      = 13;
  localparam int BIT_TX_LSLOT      = 14;
  localparam int BIT_RX_LSLOT      = 15;
  localparam int BIT_TAG           = 16;
  localparam int BIT_CMD_DATA      = 17;
  localparam int BIT_CMD_ADDR      = 18;

  // Side grouping used to gate the interrupt request
  localparam logic [FLAG_W-1:0] RX_GROUP    = 19'h7_ACCC;
  localparam logic [FLAG_W-1:0] TX_GROUP    = 19'h0_5333;
  // Bits that are sampled levels
  localparam logic [FLAG_W-1:0] LEVEL_MASK  = 19'h0_FF0F;
  // Transmit data empty of every channel reads one after reset
  localparam logic [FLAG_W-1:0] RESET_FLAGS = FLAG_W'((1 << NUM_CH) - 1) << BIT_TX_EMPTY;

  // Clear strobes from control to datapath
  typedef struct packed {
    logic [NUM_CH-1:0] clrOverrun;
    logic [NUM_CH-1:0] clrUnderrun;
    logic              clrCmdAddr;
    logic              clrCmdData;
    logic              clrTag;
  } clrStrobes_t;

endpackage

// File: rtl/sai_change_flag.sv
// Holds the last received value of one field and flags any change.
module sai_change_flag #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         valid,
  input  logic [W-1:0] value,
  input  logic         clr,
  output logic         flag
);

  logic [W-1:0] prevQ;
  logic         differs;

  assign differs = valid && (value != prevQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevQ <= '0;
      flag  <= 1'b0;
    end else begin
      if (valid) prevQ <= value;
      // a change in the clearing cycle keeps the flag set
      if (differs)  flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

endmodule

// File: rtl/sai_irq_ctrl.sv
// Decodes bus strobes into clear strobes; owns the two-step arming state.
module sai_irq_ctrl
  import sai_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              statusRd,
  input  logic [NUM_CH-1:0] rxDataRd,
  input  logic [NUM_CH-1:0] txDataWr,
  input  logic              cmdAddrRd,
  input  logic              cmdDataRd,
  input  logic              tagRd,
  input  logic [NUM_CH-1:0] overrunFlag,
  input  logic [NUM_CH-1:0] underrunFlag,
  input  logic [NUM_CH-1:0] rxOverrunEv,
  input  logic [NUM_CH-1:0] txUnderrunEv,
  output clrStrobes_t       strobes
);

  logic [NUM_CH-1:0] clrOvrVec;
  logic [NUM_CH-1:0] clrUndVec;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic armOvrQ;
    logic armUndQ;

    // a fresh event cancels the pending clear; a status read arms
    always_ff @(posedge clk) begin
      if (!rstN)                            armOvrQ <= 1'b0;
      else if (rxOverrunEv[c])              armOvrQ <= 1'b0;
      else if (statusRd && overrunFlag[c])  armOvrQ <= 1'b1;
      else if (rxDataRd[c])                 armOvrQ <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rstN)                            armUndQ <= 1'b0;
      else if (txUnderrunEv[c])             armUndQ <= 1'b0;
      else if (statusRd && underrunFlag[c]) armUndQ <= 1'b1;
      else if (txDataWr[c])                 armUndQ <= 1'b0;
    end

    assign clrOvrVec[c] = armOvrQ && rxDataRd[c];
    assign clrUndVec[c] = armUndQ && txDataWr[c];
  end

  always_comb begin
    strobes.clrOverrun  = clrOvrVec;
    strobes.clrUnderrun = clrUndVec;
    strobes.clrCmdAddr  = cmdAddrRd;
    strobes.clrCmdData  = cmdDataRd;
    strobes.clrTag      = tagRd;
  end

endmodule

// File: rtl/sai_irq_datapath.sv
// Flag storage, change detection, word assembly and interrupt gating.
module sai_irq_datapath
  import sai_irq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 20,
  parameter int TAG_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                firstBitDone,
  input  logic [NUM_CH-1:0]   rxDataReady,
  input  logic [NUM_CH-1:0]   txDataEmpty,
  input  logic [NUM_CH-1:0]   rxFifoFull,
  input  logic [NUM_CH-1:0]   txFifoEmpty,
  input  logic                txFrameSync,
  input  logic                rxFrameSync,
  input  logic                txLastSlot,
  input  logic                rxLastSlot,
  input  logic [NUM_CH-1:0]   rxOverrunEv,
  input  logic [NUM_CH-1:0]   txUnderrunEv,
  input  logic                ac97Valid,
  input  logic [ADDR_W-1:0]   ac97CmdAddr,
  input  logic [DATA_W-1:0]   ac97CmdData,
  input  logic [TAG_W-1:0]    ac97Tag,
  input  logic                txEnable,
  input  logic                rxEnable,
  input  logic [FLAG_W-1:0]   irqEnable,
  input  clrStrobes_t         strobes,
  output logic [NUM_CH-1:0]   overrunFlag,
  output logic [NUM_CH-1:0]   underrunFlag,
  output logic [STATUS_W-1:0] statusWord,
  output logic                irq
);

  localparam int PAD_W = STATUS_W - FLAG_W;

  logic [FLAG_W-1:0] levelIn;
  logic [FLAG_W-1:0] levelQ;
  logic [FLAG_W-1:0] flags;
  logic [FLAG_W-1:0] sideGate;
  logic              addrChg;
  logic              dataChg;
  logic              tagChg;

  // Pack the sampled levels into their word positions
  always_comb begin
    levelIn = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      levelIn[BIT_TX_EMPTY + c]      = txDataEmpty[c];
      levelIn[BIT_RX_READY + c]      = rxDataReady[c];
      levelIn[BIT_TX_FIFO_EMPTY + c] = txFifoEmpty[c];
      levelIn[BIT_RX_FIFO_FULL + c]  = rxFifoFull[c];
    end
    levelIn[BIT_TX_FSYNC] = txFrameSync;
    levelIn[BIT_RX_FSYNC] = rxFrameSync;
    levelIn[BIT_TX_LSLOT] = txLastSlot;
    levelIn[BIT_RX_LSLOT] = rxLastSlot;
  end

  // Levels refresh only once the first bit of the next word is out
  always_ff @(posedge clk) begin
    if (!rstN)             levelQ <= RESET_FLAGS & LEVEL_MASK;
    else if (firstBitDone) levelQ <= levelIn & LEVEL_MASK;
  end

  // Sticky per-channel error flags; the set event wins over the clear
  for (genvar c = 0; c < NUM_CH; c++) begin : g_sticky
    logic ovrQ;
    logic undQ;

    always_ff @(posedge clk) begin
      if (!rstN)                          ovrQ <= 1'b0;
      else if (rxOverrunEv[c])            ovrQ <= 1'b1;
      else if (strobes.clrOverrun[c])     ovrQ <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rstN)                          undQ <= 1'b0;
      else if (txUnderrunEv[c])           undQ <= 1'b1;
      else if (strobes.clrUnderrun[c])    undQ <= 1'b0;
    end

    assign overrunFlag[c]  = ovrQ;
    assign underrunFlag[c] = undQ;
  end

  sai_change_flag #(.W(ADDR_W)) u_addrChg (
    .clk(clk), .rstN(rstN), .valid(ac97Valid), .value(ac97CmdAddr),
    .clr(strobes.clrCmdAddr), .flag(addrChg)
  );

  sai_change_flag #(.W(DATA_W)) u_dataChg (
    .clk(clk), .rstN(rstN), .valid(ac97Valid), .value(ac97CmdData),
    .clr(strobes.clrCmdData), .flag(dataChg)
  );

  sai_change_flag #(.W(TAG_W)) u_tagChg (
    .clk(clk), .rstN(rstN), .valid(ac97Valid), .value(ac97Tag),
    .clr(strobes.clrTag), .flag(tagChg)
  );

  always_comb begin
    flags = levelQ;
    for (int c = 0; c < NUM_CH; c++) begin
      flags[BIT_RX_OVER + c]  = overrunFlag[c];
      flags[BIT_TX_UNDER + c] = underrunFlag[c];
    end
    flags[BIT_TAG]      = tagChg;
    flags[BIT_CMD_DATA] = dataChg;
    flags[BIT_CMD_ADDR] = addrChg;
  end

  assign statusWord = {{PAD_W{1'b0}}, flags};

  always_comb begin
    sideGate = (rxEnable ? RX_GROUP : '0) | (txEnable ? TX_GROUP : '0);
    irq      = |(flags & irqEnable & sideGate);
  end

endmodule

// File: rtl/sai_irq_status.sv
// Thin top: control block plus datapath.
module sai_irq_status
  import sai_irq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 20,
  parameter int TAG_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                firstBitDone,
  input  logic [NUM_CH-1:0]   rxDataReady,
  input  logic [NUM_CH-1:0]   txDataEmpty,
  input  logic [NUM_CH-1:0]   rxFifoFull,
  input  logic [NUM_CH-1:0]   txFifoEmpty,
  input  logic                txFrameSync,
  input  logic                rxFrameSync,
  input  logic                txLastSlot,
  input  logic                rxLastSlot,
  input  logic [NUM_CH-1:0]   rxOverrunEv,
  input  logic [NUM_CH-1:0]   txUnderrunEv,
  input  logic                ac97Valid,
  input  logic [ADDR_W-1:0]   ac97CmdAddr,
  input  logic [DATA_W-1:0]   ac97CmdData,
  input  logic [TAG_W-1:0]    ac97Tag,
  input  logic                txEnable,
  input  logic                rxEnable,
  input  logic [FLAG_W-1:0]   irqEnable,
  input  logic                statusRd,
  input  logic [NUM_CH-1:0]   rxDataRd,
  input  logic [NUM_CH-1:0]   txDataWr,
  input  logic                cmdAddrRd,
  input  logic                cmdDataRd,
  input  logic                tagRd,
  output logic [STATUS_W-1:0] statusWord,
  output logic                irq
);

  clrStrobes_t       strobes;
  logic [NUM_CH-1:0] overrunFlag;
  logic [NUM_CH-1:0] underrunFlag;

  sai_irq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .statusRd(statusRd),
    .rxDataRd(rxDataRd), .txDataWr(txDataWr),
    .cmdAddrRd(cmdAddrRd), .cmdDataRd(cmdDataRd), .tagRd(tagRd),
    .overrunFlag(overrunFlag), .underrunFlag(underrunFlag),
    .rxOverrunEv(rxOverrunEv), .txUnderrunEv(txUnderrunEv),
    .strobes(strobes)
  );

  sai_irq_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_dp (
    .clk(clk), .rstN(rstN), .firstBitDone(firstBitDone),
    .rxDataReady(rxDataReady), .txDataEmpty(txDataEmpty),
    .rxFifoFull(rxFifoFull), .txFifoEmpty(txFifoEmpty),
    .txFrameSync(txFrameSync), .rxFrameSync(rxFrameSync),
    .txLastSlot(txLastSlot), .rxLastSlot(rxLastSlot),
    .rxOverrunEv(rxOverrunEv), .txUnderrunEv(txUnderrunEv),
    .ac97Valid(ac97Valid), .ac97CmdAddr(ac97CmdAddr),
    .ac97CmdData(ac97CmdData), .ac97Tag(ac97Tag),
    .txEnable(txEnable), .rxEnable(rxEnable), .irqEnable(irqEnable),
    .strobes(strobes),
    .overrunFlag(overrunFlag), .underrunFlag(underrunFlag),
    .statusWord(statusWord), .irq(irq)
  );

endmodule

// File: rtl/sai_irq_status_chk.sv
module sai_irq_status_chk
  import sai_irq_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                firstBitDone,
  input logic [NUM_CH-1:0]   rxDataReady,
  input logic [NUM_CH-1:0]   txDataEmpty,
  input logic [NUM_CH-1:0]   rxFifoFull,
  input logic [NUM_CH-1:0]   txFifoEmpty,
  input logic                txFrameSync,
  input logic                rxFrameSync,
  input logic                txLastSlot,
  input logic                rxLastSlot,
  input logic [NUM_CH-1:0]   rxOverrunEv,
  input logic [NUM_CH-1:0]   rxDataRd,
  input logic                ac97Valid,
  input logic                cmdAddrRd,
  input logic                txEnable,
  input logic                rxEnable,
  input logic [STATUS_W-1:0] statusWord,
  input logic                irq
);

  logic [FLAG_W-1:0] levelPacked;

  always_comb begin
    levelPacked = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      levelPacked[BIT_TX_EMPTY + c]      = txDataEmpty[c];
      levelPacked[BIT_RX_READY + c]      = rxDataReady[c];
      levelPacked[BIT_TX_FIFO_EMPTY + c] = txFifoEmpty[c];
      levelPacked[BIT_RX_FIFO_FULL + c]  = rxFifoFull[c];
    end
    levelPacked[BIT_TX_FSYNC] = txFrameSync;
    levelPacked[BIT_RX_FSYNC] = rxFrameSync;
    levelPacked[BIT_TX_LSLOT] = txLastSlot;
    levelPacked[BIT_RX_LSLOT] = rxLastSlot;
  end

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[STATUS_W-1:FLAG_W] == '0); // R10

  AST_LEVEL_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    firstBitDone |=> (statusWord[FLAG_W-1:0] & LEVEL_MASK) == $past(levelPacked)); // R2

  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !firstBitDone |=> $stable(statusWord[FLAG_W-1:0] & LEVEL_MASK)); // R2

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ovr
    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rstN)
      rxOverrunEv[c] |=> statusWord[BIT_RX_OVER + c]); // R3

    AST_OVR_NEEDS_DATA_READ: assert property (@(posedge clk) disable iff (!rstN)
      (statusWord[BIT_RX_OVER + c] && !rxDataRd[c]) |=> statusWord[BIT_RX_OVER + c]); // R4
  end

  AST_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!statusWord[BIT_CMD_ADDR] && !ac97Valid) |=> !statusWord[BIT_CMD_ADDR]); // R6

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[BIT_CMD_ADDR] && !cmdAddrRd) |=> statusWord[BIT_CMD_ADDR]); // R6

  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEnable && !txEnable) |-> !irq); // R11

endmodule

bind sai_irq_status sai_irq_status_chk u_chk (.*);

// File: tb/sim_sai_irq_status.sv
`timescale 1ns/1ps
module sim_sai_irq_status;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        firstBitDone = 1'b0;
  logic [1:0]  rxDataReady = '0, txDataEmpty = '0, rxFifoFull = '0, txFifoEmpty = '0;
  logic        txFrameSync = 1'b0, rxFrameSync = 1'b0, txLastSlot = 1'b0, rxLastSlot = 1'b0;
  logic [1:0]  rxOverrunEv = '0, txUnderrunEv = '0;
  logic        ac97Valid = 1'b0;
  logic [19:0] ac97CmdAddr = '0, ac97CmdData = '0;
  logic [15:0] ac97Tag = '0;
  logic        txEnable = 1'b0, rxEnable = 1'b0;
  logic [18:0] irqEnable = '0;
  logic        statusRd = 1'b0;
  logic [1:0]  rxDataRd = '0, txDataWr = '0;
  logic        cmdAddrRd = 1'b0, cmdDataRd = 1'b0, tagRd = 1'b0;
  logic [31:0] statusWord;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  sai_irq_status u0 (
    .clk(clk), .rstN(rstN), .firstBitDone(firstBitDone),
    .rxDataReady(rxDataReady), .txDataEmpty(txDataEmpty),
    .rxFifoFull(rxFifoFull), .txFifoEmpty(txFifoEmpty),
    .txFrameSync(txFrameSync), .rxFrameSync(rxFrameSync),
    .txLastSlot(txLastSlot), .rxLastSlot(rxLastSlot),
    .rxOverrunEv(rxOverrunEv), .txUnderrunEv(txUnderrunEv),
    .ac97Valid(ac97Valid), .ac97CmdAddr(ac97CmdAddr),
    .ac97CmdData(ac97CmdData), .ac97Tag(ac97Tag),
    .txEnable(txEnable), .rxEnable(rxEnable), .irqEnable(irqEnable),
    .statusRd(statusRd), .rxDataRd(rxDataRd), .txDataWr(txDataWr),
    .cmdAddrRd(cmdAddrRd), .cmdDataRd(cmdDataRd), .tagRd(tagRd),
    .statusWord(statusWord), .irq(irq)
  );

  // {firstBitDone, level stimulus in word positions, expected low half}
  localparam logic [32:0] VEC [0:7] = '{
    33'h1_0001_0001,
    33'h0_FF0F_0001,
    33'h1_FF0F_FF0F,
    33'h1_A50A_A50A,
    33'h0_0000_A50A,
    33'h1_5A05_5A05,
    33'h1_0000_0000,
    33'h1_3C0C_3C0C
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // inputs change on the falling edge; results are read on the next falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setLevels(input logic [15:0] s);
    txDataEmpty = s[1:0];
    rxDataReady = s[3:2];
    txFifoEmpty = s[9:8];
    rxFifoFull  = s[11:10];
    txFrameSync = s[12];
    rxFrameSync = s[13];
    txLastSlot  = s[14];
    rxLastSlot  = s[15];
  endtask

  task automatic ac97Send(input logic [19:0] a, input logic [19:0] d, input logic [15:0] t);
    ac97CmdAddr = a; ac97CmdData = d; ac97Tag = t; ac97Valid = 1'b1;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish();
  end

  initial begin
    @(negedge clk); step(); step();
    rstN = 1'b1;
    step();
    check("R1 reset word", statusWord, 32'h0000_0003);
    check("R1 reset irq", {31'b0, irq}, 32'h0);

    // table walk for level sampling (R2)
    for (int i = 0; i < 8; i++) begin
      firstBitDone = VEC[i][32];
      setLevels(VEC[i][31:16]);
      step();
      check($sformatf("R2 vector %0d", i), statusWord, {16'h0, VEC[i][15:0]});
    end
    firstBitDone = 1'b1; setLevels(16'h0); step(); firstBitDone = 1'b0;
    check("R2 clear levels", statusWord, 32'h0);

    // overrun ch0 (R3 R4 R5 R9)
    rxOverrunEv = 2'b01; step(); rxOverrunEv = '0;
    check("R3 overrun ch0 set", statusWord, 32'h40);
    rxDataRd = 2'b01; step(); rxDataRd = '0;
    check("R4 data read without status read", statusWord, 32'h40);
    statusRd = 1'b1; rxDataRd = 2'b01; step(); statusRd = 1'b0; rxDataRd = '0;
    check("R4 same-cycle status and data read", statusWord, 32'h40);
    rxOverrunEv = 2'b01; step(); rxOverrunEv = '0;
    rxDataRd = 2'b01; step(); rxDataRd = '0;
    check("R5 new overrun cancels clear", statusWord, 32'h40);
    statusRd = 1'b1; step(); statusRd = 1'b0;
    rxDataRd = 2'b01; step(); rxDataRd = '0;
    check("R4 two-step clear", statusWord, 32'h0);
    rxOverrunEv = 2'b01; step(); rxOverrunEv = '0;
    statusRd = 1'b1; step(); statusRd = 1'b0;
    rxOverrunEv = 2'b01; rxDataRd = 2'b01; step(); rxOverrunEv = '0; rxDataRd = '0;
    check("R9 event beats clear", statusWord, 32'h40);
    rxDataRd = 2'b01; step(); rxDataRd = '0;
    check("R5 disarmed after event", statusWord, 32'h40);
    statusRd = 1'b1; step(); statusRd = 1'b0;
    rxDataRd = 2'b01; step(); rxDataRd = '0;
    check("R4 overrun cleared", statusWord, 32'h0);

    // underrun ch1
    txUnderrunEv = 2'b10; step(); txUnderrunEv = '0;
    check("R3 underrun ch1 set", statusWord, 32'h20);
    statusRd = 1'b1; step(); statusRd = 1'b0;
    txDataWr = 2'b01; step(); txDataWr = '0;
    check("R4 wrong channel write", statusWord, 32'h20);
    txDataWr = 2'b10; step(); txDataWr = '0;
    check("R4 underrun cleared", statusWord, 32'h0);

    // change-detect flags (R6 R7 R8 R9)
    ac97Send(20'h5, 20'h0, 16'h0); step(); ac97Valid = 1'b0;
    check("R6 address change sets", statusWord, 32'h0004_0000);
    cmdDataRd = 1'b1; step(); cmdDataRd = 1'b0;
    check("R6 other read keeps flag", statusWord, 32'h0004_0000);
    cmdAddrRd = 1'b1; step(); cmdAddrRd = 1'b0;
    check("R6 address read clears", statusWord, 32'h0);
    ac97Send(20'h5, 20'h123, 16'h0); step(); ac97Valid = 1'b0;
    check("R7 data change, same address", statusWord, 32'h0002_0000);
    ac97Send(20'h5, 20'h123, 16'h7); tagRd = 1'b1; step(); ac97Valid = 1'b0; tagRd = 1'b0;
    check("R8 R9 tag change with read", statusWord, 32'h0003_0000);
    tagRd = 1'b1; step(); tagRd = 1'b0;
    check("R8 tag read clears", statusWord, 32'h0002_0000);
    cmdDataRd = 1'b1; step(); cmdDataRd = 1'b0;
    check("R7 data read clears", statusWord, 32'h0);
    ac97Send(20'h5, 20'h123, 16'h7); step(); ac97Valid = 1'b0;
    check("R7 R8 repeat values no change", statusWord, 32'h0);
    ac97Send(20'h9, 20'h123, 16'h7); rxOverrunEv = 2'b11; txUnderrunEv = 2'b11;
    step(); ac97Valid = 1'b0; rxOverrunEv = '0; txUnderrunEv = '0;
    check("R10 reserved bits zero", {13'b0, statusWord[31:19]}, 32'h0);
    check("R3 both channels both events", statusWord, 32'h0004_00F0);

    // interrupt gating (R11 R12)
    irqEnable = 19'h4_0000; txEnable = 1'b1; rxEnable = 1'b0; #1;
    check("R11 rx bit needs rx enable", {31'b0, irq}, 32'h0);
    rxEnable = 1'b1; #1;
    check("R12 irq follows enable at once", {31'b0, irq}, 32'h1);
    irqEnable = 19'h2_0000; #1;
    check("R11 masked bit", {31'b0, irq}, 32'h0);
    irqEnable = 19'h0_0000; @(negedge clk);
    cmdAddrRd = 1'b1; firstBitDone = 1'b1; setLevels(16'h0001); step();
    cmdAddrRd = 1'b0; firstBitDone = 1'b0;
    irqEnable = 19'h0_0001; rxEnable = 1'b1; txEnable = 1'b0; #1;
    check("R11 tx bit needs tx enable", {31'b0, irq}, 32'h0);
    txEnable = 1'b1; #1;
    check("R11 tx bit raises irq", {31'b0, irq}, 32'h1);

    finish();
  end

endmodule